// File: doc/BRIEF.md
# Staged Configuration Write Controller

This block is a register-mapped slave that lets a host update a channel's internal configuration space one word at a time. The host stages three values in separate registers: a logical channel number, a word offset into that channel's configuration space, and a 16-bit data word. It then writes a control/status register (CSR) with a mode field set to direct-write and the go bit set. The block copies the staged values into a downstream write request and raises a busy flag. The flag stays up until the downstream side accepts the request.

A multi-word update is a series of such transfers. The host rewrites the offset (one higher each time) and the data, sets go again, and polls busy between steps. Writes that arrive while a transfer is in flight are dropped and latch a sticky error flag. The host clears that flag by writing 1 to its CSR bit.

The downstream side is a valid/ready write port. `dn_valid` is raised with the channel, offset and data payload. Both the strobe and the payload stay unchanged until the cycle in which `dn_ready` is also high. The downstream side may hold `dn_ready` low for any number of cycles to apply back-pressure. The host side has no back-pressure: the host must poll busy before writing again.

Top module: `stage_cfg_writer`

## Requirements
- R1: After reset, `dn_valid` is 0, and reads of the channel (0x38), CSR (0x3A), offset (0x3B) and data (0x3C) registers return 0.
- R2: A read returns its data on `host_rdata` with `host_rvalid` high in the cycle after `host_rd`. The channel, offset and data registers read back the low 10, 11 and 16 bits written, zero-extended.
- R3: A CSR write with bit 0 (go) = 1 and bits [3:2] (mode) = 2'b01, made while idle, raises `dn_valid` on the next cycle. The payload on `dn_chan`, `dn_ofs` and `dn_data` is the staged channel, offset and data.
- R4: A CSR write whose mode field is not 2'b01, or whose go bit is 0, starts no transfer and stores the mode field. The CSR reads back as {err[4], mode[3:2], busy[1], go[0]}.
- R5: While `dn_valid` is high and `dn_ready` is low, `dn_valid` and the payload hold. After the cycle where both are high, `dn_valid` and busy are 0.
- R6: CSR bits 1 (busy) and 0 (go) read as 1 from the cycle after launch until the request is accepted. Both self-clear after the acceptance.
- R7: A write to any of the four mapped registers while busy changes no register and no payload, and sets CSR bit 4 (err).
- R8: CSR bit 4 is sticky. An idle CSR write with bit 4 = 1 clears it, and one with bit 4 = 0 leaves it set.
- R9: Addresses other than 0x38, 0x3A, 0x3B, 0x3C read as 0, and writes to them change nothing.
- R10: Successive go writes with offsets 0, 1, 2 produce exactly one downstream acceptance each, carrying the matching offset and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| dn_valid | output | 1 | Downstream write request |
| dn_ready | input | 1 | Downstream accepts the request when high with `dn_valid` |
| dn_chan | output | 10 | Target logical channel |
| dn_ofs | output | 11 | Target word offset |
| dn_data | output | 16 | Word to write |

## Verification
Each result has a fixed latency:
- Register writes take effect at the clock edge that samples `host_wr`.
- A launch shows on `dn_valid` one edge after the go write.
- Read data lands one edge after `host_rd`.
- `dn_valid` and busy drop one edge after the accepting cycle.

The bench drives inputs on the falling edge and samples on the next falling edge, so every check sits exactly one registered stage after its stimulus. The bench holds `dn_ready` low across several cycles to check that the request and payload stay steady, then counts acceptances at rising edges to confirm one per launch.

// File: rtl/stage_cfg_pkg.sv
package stage_cfg_pkg;
  localparam int unsigned ADR_CHAN = 32'h38;
  localparam int unsigned ADR_CSR  = 32'h3A;
  localparam int unsigned ADR_OFS  = 32'h3B;
  localparam int unsigned ADR_DATA = 32'h3C;

  localparam int CSR_GO   = 0;
  localparam int CSR_BUSY = 1;
  localparam int CSR_MLO  = 2;
  localparam int CSR_MHI  = 3;
  localparam int CSR_ERR  = 4;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_RSVD2  = 2'b10,
    MODE_RSVD3  = 2'b11
  } mode_e;

  typedef struct packed {
    logic chan;
    logic csr;
    logic ofs;
    logic data;
  } sel_t;

  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_REQ  = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/stage_cfg_decode.sv
module stage_cfg_decode
  import stage_cfg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic              any_hit
);
  localparam int NREG = 4;
  localparam int unsigned MAP [NREG] = '{ADR_CHAN, ADR_CSR, ADR_OFS, ADR_DATA};

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = (addr == ADDR_W'(MAP[g]));
  end

  assign sel.chan = hit[0];
  assign sel.csr  = hit[1];
  assign sel.ofs  = hit[2];
  assign sel.data = hit[3];
  assign any_hit  = |hit;
endmodule

// File: rtl/stage_cfg_regs.sv
module stage_cfg_regs
  import stage_cfg_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int CH_W   = 10,
  parameter int OFS_W  = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [HOST_W-1:0] wdata,
  input  sel_t              sel,
  input  logic              any_hit,
  input  logic              busy,
  output logic [CH_W-1:0]   chan_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [DATA_W-1:0] data_q,
  output logic [1:0]        mode_q,
  output logic              err_q,
  output logic              launch
);
  logic wr_ok;
  logic wr_blocked;
  logic [1:0] wmode;

  assign wr_ok      = wr && !busy;
  assign wr_blocked = wr && busy && any_hit;
  assign wmode      = wdata[CSR_MHI:CSR_MLO];
  assign launch     = wr_ok && sel.csr && wdata[CSR_GO] && (wmode == MODE_DIRECT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= '0;
      ofs_q  <= '0;
      data_q <= '0;
      mode_q <= MODE_NONE;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok && sel.chan) chan_q <= wdata[CH_W-1:0];
      if (wr_ok && sel.ofs)  ofs_q  <= wdata[OFS_W-1:0];
      if (wr_ok && sel.data) data_q <= wdata[DATA_W-1:0];
      if (wr_ok && sel.csr)  mode_q <= wmode;
      if (wr_blocked)
        err_q <= 1'b1;
      else if (wr_ok && sel.csr && wdata[CSR_ERR])
        err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/stage_cfg_xfer.sv
module stage_cfg_xfer
  import stage_cfg_pkg::*;
#(
  parameter int CH_W   = 10,
  parameter int OFS_W  = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [CH_W-1:0]   chan_in,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              dn_ready,
  output logic              dn_valid,
  output logic [CH_W-1:0]   dn_chan,
  output logic [OFS_W-1:0]  dn_ofs,
  output logic [DATA_W-1:0] dn_data,
  output logic              busy
);
  xfer_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XF_IDLE: if (launch)   state_d = XF_REQ;
      XF_REQ:  if (dn_ready) state_d = XF_IDLE;
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      dn_chan <= '0;
      dn_ofs  <= '0;
      dn_data <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == XF_IDLE && launch) begin
        dn_chan <= chan_in;
        dn_ofs  <= ofs_in;
        dn_data <= data_in;
      end
    end
  end

  assign dn_valid = (state_q == XF_REQ);
  assign busy     = (state_q != XF_IDLE);
endmodule

// File: rtl/stage_cfg_rdport.sv
module stage_cfg_rdport
  import stage_cfg_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int CH_W   = 10,
  parameter int OFS_W  = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  sel_t              sel,
  input  logic [CH_W-1:0]   chan_q,
  input  logic [OFS_W-1:0]  ofs_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [1:0]        mode_q,
  input  logic              err_q,
  input  logic              busy,
  input  logic              pending,
  output logic [HOST_W-1:0] rdata,
  output logic              rvalid
);
  logic [HOST_W-1:0] csr_view;
  logic [HOST_W-1:0] mux;

  always_comb begin
    csr_view = '0;
    csr_view[CSR_GO]          = pending;
    csr_view[CSR_BUSY]        = busy;
    csr_view[CSR_MHI:CSR_MLO] = mode_q;
    csr_view[CSR_ERR]         = err_q;
  end

  always_comb begin
    mux = '0;
    unique case (1'b1)
      sel.chan: mux = HOST_W'(chan_q);
      sel.csr:  mux = csr_view;
      sel.ofs:  mux = HOST_W'(ofs_q);
      sel.data: mux = HOST_W'(data_q);
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= mux;
    end
  end
endmodule

// File: rtl/stage_cfg_writer.sv
module stage_cfg_writer
  import stage_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HOST_W = 32,
  parameter int CH_W   = 10,
  parameter int OFS_W  = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [CH_W-1:0]   dn_chan,
  output logic [OFS_W-1:0]  dn_ofs,
  output logic [DATA_W-1:0] dn_data
);
  sel_t              sel;
  logic              any_hit;
  logic              busy;
  logic              launch;
  logic [CH_W-1:0]   chan_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        mode_q;
  logic              err_q;

  stage_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (host_addr),
    .sel     (sel),
    .any_hit (any_hit)
  );

  stage_cfg_regs #(
    .HOST_W(HOST_W), .CH_W(CH_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (host_wr),
    .wdata   (host_wdata),
    .sel     (sel),
    .any_hit (any_hit),
    .busy    (busy),
    .chan_q  (chan_q),
    .ofs_q   (ofs_q),
    .data_q  (data_q),
    .mode_q  (mode_q),
    .err_q   (err_q),
    .launch  (launch)
  );

  stage_cfg_xfer #(
    .CH_W(CH_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .chan_in  (chan_q),
    .ofs_in   (ofs_q),
    .data_in  (data_q),
    .dn_ready (dn_ready),
    .dn_valid (dn_valid),
    .dn_chan  (dn_chan),
    .dn_ofs   (dn_ofs),
    .dn_data  (dn_data),
    .busy     (busy)
  );

  stage_cfg_rdport #(
    .HOST_W(HOST_W), .CH_W(CH_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (host_rd),
    .sel     (sel),
    .chan_q  (chan_q),
    .ofs_q   (ofs_q),
    .data_q  (data_q),
    .mode_q  (mode_q),
    .err_q   (err_q),
    .busy    (busy),
    .pending (dn_valid),
    .rdata   (host_rdata),
    .rvalid  (host_rvalid)
  );
endmodule

// File: rtl/stage_cfg_writer_chk.sv
module stage_cfg_writer_chk #(
  parameter int ADDR_W = 8,
  parameter int HOST_W = 32,
  parameter int CH_W   = 10,
  parameter int OFS_W  = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [HOST_W-1:0] host_wdata,
  input logic              host_rvalid,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [CH_W-1:0]   dn_chan,
  input logic [OFS_W-1:0]  dn_ofs,
  input logic [DATA_W-1:0] dn_data,
  input logic              busy,
  input logic              err_q
);
  logic csr_hit, map_hit;
  assign csr_hit = (host_addr == ADDR_W'(32'h3A));
  assign map_hit = csr_hit || (host_addr == ADDR_W'(32'h38)) ||
                   (host_addr == ADDR_W'(32'h3B)) || (host_addr == ADDR_W'(32'h3C));

  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && csr_hit && !busy && host_wdata[0] && host_wdata[3:2] == 2'b01) |=> dn_valid);

  assert_no_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_valid && !(host_wr && csr_hit && host_wdata[0] && host_wdata[3:2] == 2'b01)) |=> !dn_valid);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_chan) && $stable(dn_ofs) && $stable(dn_data)));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready) |=> (!dn_valid && !busy));

  assert_busy_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && map_hit) |=> err_q);

  assert_rd_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);
endmodule

bind stage_cfg_writer stage_cfg_writer_chk #(
  .ADDR_W(ADDR_W), .HOST_W(HOST_W), .CH_W(CH_W), .OFS_W(OFS_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rvalid (host_rvalid),
  .dn_valid    (dn_valid),
  .dn_ready    (dn_ready),
  .dn_chan     (dn_chan),
  .dn_ofs      (dn_ofs),
  .dn_data     (dn_data),
  .busy        (busy),
  .err_q       (err_q)
);

// File: tb/stage_cfg_writer_bench.sv
module stage_cfg_writer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic [9:0]  dn_chan;
  logic [10:0] dn_ofs;
  logic [15:0] dn_data;

  int total = 0;
  int bad = 0;
  int hs_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stage_cfg_writer u_stage_cfg_writer (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_chan(dn_chan), .dn_ofs(dn_ofs), .dn_data(dn_data)
  );

  always @(posedge clk) if (rst_n && dn_valid && dn_ready) hs_cnt <= hs_cnt + 1;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h38, 32'h0000_0155, 32'h155},   // R2 channel
    '{8'h38, 32'hFFFF_FFFF, 32'h3FF},   // R2 channel width
    '{8'h3B, 32'h0000_FFFF, 32'h7FF},   // R2 offset width
    '{8'h3B, 32'h0000_0123, 32'h123},   // R2 offset
    '{8'h3C, 32'h0000_2820, 32'h2820},  // R2 data
    '{8'h3C, 32'hABCD_1234, 32'h1234},  // R2 data width
    '{8'h3A, 32'h0000_0008, 32'h8},     // R4 mode 2, no go
    '{8'h3A, 32'h0000_0009, 32'h8},     // R4 go with mode 2
    '{8'h3A, 32'h0000_000D, 32'hC},     // R4 go with mode 3
    '{8'h3A, 32'h0000_0004, 32'h4},     // R4 mode 1, no go
    '{8'h40, 32'h0000_0005, 32'h0},     // R9 unmapped
    '{8'h39, 32'h0000_0007, 32'h0}      // R9 gap address
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R2 rvalid", {31'b0, host_rvalid}, 32'h1);
    d = host_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int hs0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 dn_valid", {31'b0, dn_valid}, 32'h0);
    hread(8'h38, r); chk("R1 chan", r, 32'h0);
    hread(8'h3A, r); chk("R1 csr", r, 32'h0);
    hread(8'h3B, r); chk("R1 ofs", r, 32'h0);
    hread(8'h3C, r); chk("R1 data", r, 32'h0);

    // table walk: R2, R4, R9
    for (int i = 0; i < NV; i++) begin
      hwrite(VECS[i].addr, VECS[i].wdata);
      chk("R4 no launch", {31'b0, dn_valid}, 32'h0);
      hread(VECS[i].addr, r);
      chk("R2/R4/R9 readback", r, VECS[i].exp);
    end
    hread(8'h38, r); chk("R9 chan untouched", r, 32'h3FF);

    // R3 launch with back-pressure
    hwrite(8'h38, 32'h3);
    hwrite(8'h3B, 32'h0);
    hwrite(8'h3C, 32'h2820);
    hwrite(8'h3A, 32'h5);
    chk("R3 dn_valid", {31'b0, dn_valid}, 32'h1);
    chk("R3 dn_chan", {22'b0, dn_chan}, 32'h3);
    chk("R3 dn_ofs", {21'b0, dn_ofs}, 32'h0);
    chk("R3 dn_data", {16'b0, dn_data}, 32'h2820);
    hread(8'h3A, r); chk("R6 csr busy", r, 32'h7);
    repeat (3) @(negedge clk);
    chk("R5 hold valid", {31'b0, dn_valid}, 32'h1);
    chk("R5 hold data", {16'b0, dn_data}, 32'h2820);

    // R7 write while busy
    hwrite(8'h3C, 32'h1111);
    hwrite(8'h3B, 32'h55);
    chk("R7 payload data", {16'b0, dn_data}, 32'h2820);
    chk("R7 payload ofs", {21'b0, dn_ofs}, 32'h0);
    hread(8'h3A, r); chk("R7 err set", r, 32'h17);

    @(negedge clk); dn_ready = 1'b1;
    @(negedge clk); dn_ready = 1'b0;
    chk("R5 release", {31'b0, dn_valid}, 32'h0);
    hread(8'h3A, r); chk("R6 self clear", r, 32'h14);
    hread(8'h3C, r); chk("R7 data unchanged", r, 32'h2820);
    hread(8'h3B, r); chk("R7 ofs unchanged", r, 32'h0);

    // R8 sticky error
    hwrite(8'h3A, 32'h04);
    hread(8'h3A, r); chk("R8 err kept", r, 32'h14);
    hwrite(8'h3A, 32'h14);
    hread(8'h3A, r); chk("R8 err cleared", r, 32'h04);

    // R10 multi-word with ready held high
    dn_ready = 1'b1;
    hs0 = hs_cnt;
    for (int k = 0; k < 3; k++) begin
      hwrite(8'h3B, k);
      hwrite(8'h3C, 32'hA000 + k);
      hwrite(8'h3A, 32'h5);
      chk("R10 valid", {31'b0, dn_valid}, 32'h1);
      chk("R10 ofs", {21'b0, dn_ofs}, k);
      chk("R10 data", {16'b0, dn_data}, 32'hA000 + k);
      @(negedge clk);
      chk("R10 accepted", {31'b0, dn_valid}, 32'h0);
    end
    chk("R10 count", hs_cnt - hs0, 32'd3);
    dn_ready = 1'b0;
    hread(8'h3A, r); chk("R6 idle csr", r, 32'h4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule